// File: doc/BRIEF.md
# Ultra DMA Write Burst Receiver (Device Side)

This block sits on the device side of a parallel disk interface. It receives a host-to-device Ultra DMA burst and passes the words to internal buffering. When firmware raises `burst_en`, the block requests service by asserting `dmarq`. Once the host acknowledges with `dmack_n` low and `stop` low, it becomes ready by driving `ddmardy_n` low. From then on it captures one 16-bit word on every transition of `hstrobe`, rising and falling alike. The words flow out through a valid/ready stream. All host-side inputs pass through two-flop synchronizers, and strobe edges are found by comparing the synchronized strobe with its value one cycle earlier.

A small skid buffer absorbs the words. When it reaches its almost-full level, the block pauses the host by raising `ddmardy_n`. It does this only after the first falling strobe edge of the burst, because a pause is not allowed before one word has moved. Words still in flight during the pause are kept. If the buffer drains, the block withdraws the pause. If the buffer stays almost full for `T_RP` cycles, the block ends the burst by negating `dmarq`, and the ready signal is already negated by then. If the host asserts `stop` after the first strobe negation, both handshake signals are negated. Raising `dmack_n` always returns the block to idle.

Top module: `udma_wr_rx`

## Requirements
- R1: After reset, `dmarq`=0, `ddmardy_n`=1, `rx_valid`=0 and `rx_overflow`=0. While the block is idle, `burst_en`=1 raises `dmarq` within 3 cycles.
- R2: After `dmack_n`=0 and `stop`=0 are presented, `ddmardy_n` falls within `RDY_DLY`+4 clock cycles.
- R3: Once `dmarq`=1 and `ddmardy_n`=0, neither changes before the first falling edge of `hstrobe` in the burst. A `stop` raised before that edge is ignored.
- R4: Every rising and every falling edge of `hstrobe` captures the word on `dd`. Words leave on `rx_data` in arrival order, and each is held stable while `rx_valid`=1 and `rx_ready`=0.
- R5: The block never pauses before the first falling strobe edge of the burst, even if the buffer is at or above `AF_LVL` when the burst starts.
- R6: After the first falling edge, the block raises `ddmardy_n` (pause) when the buffer level reaches `AF_LVL`. It lowers `ddmardy_n` again (resume) when the level drops below `AF_LVL` before the termination delay expires.
- R7: If the pause lasts, `dmarq` falls exactly `T_RP` cycles after `ddmardy_n` rose. A host that merely stops strobing never causes `dmarq` to fall.
- R8: Words that arrive during the pause or termination window are stored until the buffer holds `DEPTH` words. A word that arrives while the buffer is full is discarded and sets the sticky flag `rx_overflow`, which clears only on reset.
- R9: A `stop`=1 from the host after the first falling strobe edge makes `dmarq`=0 and `ddmardy_n`=1 within 5 cycles.
- R10: `dmack_n`=1 after acknowledgement returns the block to idle within 5 cycles, with `dmarq`=0 and `ddmardy_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_en | input | 1 | Internal request to accept a write burst |
| dmack_n | input | 1 | Host DMA acknowledge, active low |
| stop | input | 1 | Host stop request, active high |
| hstrobe | input | 1 | Host data strobe; both edges carry a word |
| dd | input | 16 | Host data bus |
| dmarq | output | 1 | Device DMA request, active high |
| ddmardy_n | output | 1 | Device ready, active low |
| rx_data | output | 16 | Received word toward buffering |
| rx_valid | output | 1 | `rx_data` holds a word |
| rx_ready | input | 1 | Consumer takes the word when high with `rx_valid` |
| rx_overflow | output | 1 | Sticky flag: a word arrived while the buffer was full |

## Verification
The hardest state to reach is a burst that begins with the buffer already at its almost-full level. In that state, the rule against pausing before the first word conflicts with the fill level. The bench gets there by ending one burst through device termination while the consumer stays stalled, so the buffer stays full. It then starts a new burst without draining and checks that the ready signal is asserted and held until a single falling strobe edge arrives. Only after that edge may the pause appear. The exact `T_RP` spacing between the ready negation and the request negation is measured by an edge monitor that timestamps both signals.

// File: rtl/udma_wr_pkg.sv
package udma_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_LI    = 3'd2,
        ST_XFER  = 3'd3,
        ST_PAUSE = 3'd4,
        ST_DTERM = 3'd5,
        ST_HTERM = 3'd6
    } burst_st_t;

endpackage

// File: rtl/udma_in_sync.sv
module udma_in_sync #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hstrobe,
    input  logic [DW-1:0] dd,
    input  logic          dmack_n,
    input  logic          stop,
    output logic          strobe_edge,
    output logic          strobe_fall,
    output logic [DW-1:0] word,
    output logic          dmack_n_s,
    output logic          stop_s
);

    typedef struct packed {
        logic [1:0]    stb;
        logic          stb_prev;
        logic [DW-1:0] d1;
        logic [DW-1:0] d2;
        logic [1:0]    ack;
        logic [1:0]    stp;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.stb      = {sync_q.stb[0], hstrobe};
        sync_d.stb_prev = sync_q.stb[1];
        sync_d.d1       = dd;
        sync_d.d2       = sync_q.d1;
        sync_d.ack      = {sync_q.ack[0], dmack_n};
        sync_d.stp      = {sync_q.stp[0], stop};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{stb: 2'b11, stb_prev: 1'b1, d1: '0, d2: '0,
                        ack: 2'b11, stp: 2'b11};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign strobe_edge = sync_q.stb[1] ^ sync_q.stb_prev;
    assign strobe_fall = sync_q.stb_prev & ~sync_q.stb[1];
    assign word        = sync_q.d2;
    assign dmack_n_s   = sync_q.ack[1];
    assign stop_s      = sync_q.stp[1];

endmodule

// File: rtl/udma_skid_fifo.sv
module udma_skid_fifo #(
    parameter int DW     = 16,
    parameter int DEPTH  = 8,
    parameter int AF_LVL = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          almost_full,
    output logic          overflow
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
        logic                     ovf;
    } fifo_t;

    fifo_t fifo_d, fifo_q;
    logic  full, push, pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full        = (fifo_q.cnt == CW'(DEPTH));
    assign rd_valid    = (fifo_q.cnt != '0);
    assign rd_data     = fifo_q.mem[fifo_q.rp];
    assign almost_full = (fifo_q.cnt >= CW'(AF_LVL));
    assign overflow    = fifo_q.ovf;
    assign push        = wr_en && !full;
    assign pop         = rd_valid && rd_ready;

    always_comb begin
        fifo_d = fifo_q;
        if (wr_en && full) begin
            fifo_d.ovf = 1'b1;
        end
        if (push) begin
            fifo_d.mem[fifo_q.wp] = wr_data;
            fifo_d.wp             = ptr_inc(fifo_q.wp);
        end
        if (pop) begin
            fifo_d.rp = ptr_inc(fifo_q.rp);
        end
        case ({push, pop})
            2'b10:   fifo_d.cnt = fifo_q.cnt + 1'b1;
            2'b01:   fifo_d.cnt = fifo_q.cnt - 1'b1;
            default: fifo_d.cnt = fifo_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_q <= '0;
        end else begin
            fifo_q <= fifo_d;
        end
    end

    // R8: occupancy never exceeds the storage depth
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_q.cnt <= CW'(DEPTH));

    // R8: the overflow flag is sticky
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R8: a write into a full buffer with no read leaves it full
    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_ready) |=> (fifo_q.cnt == CW'(DEPTH)));

    // R4: a stalled output word is held
    a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

// File: rtl/udma_burst_ctrl.sv
module udma_burst_ctrl
    import udma_wr_pkg::*;
#(
    parameter int RDY_DLY = 2,
    parameter int T_RP    = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_en,
    input  logic dmack_n_s,
    input  logic stop_s,
    input  logic strobe_edge,
    input  logic strobe_fall,
    input  logic almost_full,
    output logic dmarq,
    output logic ddmardy_n,
    output logic capture
);

    localparam int MAXC = (RDY_DLY > T_RP) ? RDY_DLY : T_RP;
    localparam int CNTW = $clog2(MAXC + 1);

    typedef struct packed {
        burst_st_t       state;
        logic [CNTW-1:0] cnt;
        logic            first_neg;
        logic            rq;
        logic            rdy_n;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  in_data_phase;

    assign in_data_phase = (ctrl_q.state == ST_XFER)  || (ctrl_q.state == ST_PAUSE) ||
                           (ctrl_q.state == ST_DTERM) || (ctrl_q.state == ST_HTERM);
    assign capture       = strobe_edge && in_data_phase && !dmack_n_s;

    always_comb begin
        ctrl_d = ctrl_q;
        if (strobe_fall && (ctrl_q.state == ST_XFER) && !dmack_n_s) begin
            ctrl_d.first_neg = 1'b1;
        end
        case (ctrl_q.state)
            ST_IDLE: begin
                ctrl_d.rq        = 1'b0;
                ctrl_d.rdy_n     = 1'b1;
                ctrl_d.first_neg = 1'b0;
                if (burst_en) begin
                    ctrl_d.state = ST_REQ;
                    ctrl_d.rq    = 1'b1;
                end
            end
            ST_REQ: begin
                if (!dmack_n_s && !stop_s) begin
                    ctrl_d.state = ST_LI;
                    ctrl_d.cnt   = '0;
                end
            end
            ST_LI: begin
                if (ctrl_q.cnt == CNTW'(RDY_DLY - 1)) begin
                    ctrl_d.state = ST_XFER;
                    ctrl_d.rdy_n = 1'b0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            ST_XFER: begin
                if (ctrl_q.first_neg && stop_s) begin
                    ctrl_d.state = ST_HTERM;
                    ctrl_d.rq    = 1'b0;
                    ctrl_d.rdy_n = 1'b1;
                end else if (ctrl_q.first_neg && almost_full) begin
                    ctrl_d.state = ST_PAUSE;
                    ctrl_d.rdy_n = 1'b1;
                    ctrl_d.cnt   = '0;
                end
            end
            ST_PAUSE: begin
                if (stop_s) begin
                    ctrl_d.state = ST_HTERM;
                    ctrl_d.rq    = 1'b0;
                end else if (!almost_full) begin
                    ctrl_d.state = ST_XFER;
                    ctrl_d.rdy_n = 1'b0;
                end else if (ctrl_q.cnt == CNTW'(T_RP - 1)) begin
                    ctrl_d.state = ST_DTERM;
                    ctrl_d.rq    = 1'b0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            default: begin
                ctrl_d.rq    = 1'b0;
                ctrl_d.rdy_n = 1'b1;
            end
        endcase
        if (dmack_n_s && (ctrl_q.state != ST_IDLE) && (ctrl_q.state != ST_REQ)) begin
            ctrl_d.state = ST_IDLE;
            ctrl_d.rq    = 1'b0;
            ctrl_d.rdy_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, cnt: '0, first_neg: 1'b0, rq: 1'b0, rdy_n: 1'b1};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign dmarq     = ctrl_q.rq;
    assign ddmardy_n = ctrl_q.rdy_n;

    // R3: handshake held until the first strobe negation
    a_r3_hold_until_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.first_neg && dmarq && !ddmardy_n && !dmack_n_s) |=> (dmarq && !ddmardy_n));

    // R5: no pause before a word has moved
    a_r5_no_early_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_XFER && !ctrl_q.first_neg) |=> (ctrl_q.state != ST_PAUSE));

    // R7: device termination drops ready before request
    a_r7_rdy_before_rq: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dmarq) && $past(ctrl_q.state == ST_PAUSE)) |-> $past(ddmardy_n));

    // R9: host stop after the first negation ends the handshake
    a_r9_host_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_s && ctrl_q.first_neg && !dmack_n_s &&
         (ctrl_q.state == ST_XFER || ctrl_q.state == ST_PAUSE)) |=> (!dmarq && ddmardy_n));

    // R10: acknowledge release returns to idle
    a_r10_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (dmack_n_s && in_data_phase) |=> (!dmarq && ddmardy_n));

endmodule

// File: rtl/udma_wr_rx.sv
module udma_wr_rx #(
    parameter int DW      = 16,
    parameter int DEPTH   = 8,
    parameter int AF_LVL  = 6,
    parameter int RDY_DLY = 2,
    parameter int T_RP    = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst_en,
    input  logic          dmack_n,
    input  logic          stop,
    input  logic          hstrobe,
    input  logic [DW-1:0] dd,
    output logic          dmarq,
    output logic          ddmardy_n,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    input  logic          rx_ready,
    output logic          rx_overflow
);

    logic          strobe_edge, strobe_fall, dmack_n_s, stop_s;
    logic          almost_full, capture;
    logic [DW-1:0] word;

    udma_in_sync #(.DW(DW)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .hstrobe     (hstrobe),
        .dd          (dd),
        .dmack_n     (dmack_n),
        .stop        (stop),
        .strobe_edge (strobe_edge),
        .strobe_fall (strobe_fall),
        .word        (word),
        .dmack_n_s   (dmack_n_s),
        .stop_s      (stop_s)
    );

    udma_burst_ctrl #(.RDY_DLY(RDY_DLY), .T_RP(T_RP)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .burst_en    (burst_en),
        .dmack_n_s   (dmack_n_s),
        .stop_s      (stop_s),
        .strobe_edge (strobe_edge),
        .strobe_fall (strobe_fall),
        .almost_full (almost_full),
        .dmarq       (dmarq),
        .ddmardy_n   (ddmardy_n),
        .capture     (capture)
    );

    udma_skid_fifo #(.DW(DW), .DEPTH(DEPTH), .AF_LVL(AF_LVL)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (capture),
        .wr_data     (word),
        .rd_ready    (rx_ready),
        .rd_valid    (rx_valid),
        .rd_data     (rx_data),
        .almost_full (almost_full),
        .overflow    (rx_overflow)
    );

endmodule

// File: tb/sim_udma_wr_rx.sv
module sim_udma_wr_rx;

    localparam int DW = 16, DEPTH = 8, AF_LVL = 6, RDY_DLY = 2, T_RP = 40;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          burst_en = 1'b0, dmack_n = 1'b1, stop = 1'b1, hstrobe = 1'b1;
    logic [DW-1:0] dd = '0;
    logic          dmarq, ddmardy_n, rx_valid, rx_overflow;
    logic          rx_ready = 1'b0;
    logic [DW-1:0] rx_data;

    int checks = 0, errors = 0;
    int rx_cnt = 0, exp_cnt = 0;
    logic [DW-1:0] rx_mem  [64];
    logic [DW-1:0] exp_mem [64];
    int ncyc = 0, t_rise = 0, t_fall = 0;
    logic prev_rdy_n = 1'b1, prev_rq = 1'b0;

    // each entry: {expected dmarq, expected ddmardy_n, word}
    localparam logic [DW+1:0] VEC [6] = '{
        {2'b10, 16'h1234}, {2'b10, 16'hABCD}, {2'b10, 16'h0000},
        {2'b10, 16'hFFFF}, {2'b10, 16'h5A5A}, {2'b10, 16'hA5A5}
    };

    always #2.5 clk = ~clk;

    udma_wr_rx #(.DW(DW), .DEPTH(DEPTH), .AF_LVL(AF_LVL), .RDY_DLY(RDY_DLY), .T_RP(T_RP)) u0 (
        .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .dmack_n(dmack_n), .stop(stop),
        .hstrobe(hstrobe), .dd(dd), .dmarq(dmarq), .ddmardy_n(ddmardy_n),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_overflow(rx_overflow)
    );

    always @(negedge clk) begin
        ncyc++;
        if (rx_valid && rx_ready && rx_cnt < 64) begin
            rx_mem[rx_cnt] = rx_data;
            rx_cnt++;
        end
        if (prev_rdy_n == 1'b0 && ddmardy_n == 1'b1) t_rise = ncyc;
        if (prev_rq == 1'b1 && dmarq == 1'b0) t_fall = ncyc;
        prev_rdy_n = ddmardy_n;
        prev_rq    = dmarq;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic send_word(input logic [DW-1:0] w, input bit keep);
        dd = w;
        step(2);
        hstrobe = ~hstrobe;
        step(5);
        if (keep) begin
            exp_mem[exp_cnt] = w;
            exp_cnt++;
        end
    endtask

    task automatic start_burst();
        burst_en = 1'b1;
        step(3);
        dmack_n = 1'b0;
        stop    = 1'b0;
    endtask

    task automatic release_burst();
        stop     = 1'b1;
        step(2);
        dmack_n  = 1'b1;
        burst_en = 1'b0;
        step(5);
        hstrobe  = 1'b1;
        step(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 dmarq", dmarq, 0);
        chk("R1 ddmardy_n", ddmardy_n, 1);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 overflow", rx_overflow, 0);
        burst_en = 1'b1;
        step(3);
        chk("R1 request", dmarq, 1);

        // R2 ready latency
        dmack_n = 1'b0;
        stop    = 1'b0;
        n = 0;
        while (ddmardy_n && n < 30) begin
            step(1);
            n++;
        end
        chk("R2 ready within bound", (n <= RDY_DLY + 4), 1);

        // R3 stop before first negation is ignored
        stop = 1'b1;
        step(10);
        chk("R3 dmarq held", dmarq, 1);
        chk("R3 ready held", ddmardy_n, 0);
        stop = 1'b0;
        step(3);

        // R4 table walk, both strobe edges
        rx_ready = 1'b1;
        for (int i = 0; i < 6; i++) begin
            send_word(VEC[i][DW-1:0], 1'b1);
            chk("R4 dmarq during walk", dmarq, VEC[i][DW+1]);
            chk("R4 ready during walk", ddmardy_n, VEC[i][DW]);
        end
        step(4);
        chk("R4 word count", rx_cnt, 6);
        for (int i = 0; i < 6; i++) chk("R4 word order", rx_mem[i], VEC[i][DW-1:0]);

        // R7 silent host does not end the burst
        step(100);
        chk("R7 silence keeps dmarq", dmarq, 1);
        chk("R7 silence keeps ready", ddmardy_n, 0);

        // R6 pause at almost-full level
        rx_ready = 1'b0;
        for (int i = 0; i < AF_LVL - 1; i++) send_word(16'h1000 + 16'(i), 1'b1);
        chk("R6 no pause below level", ddmardy_n, 0);
        send_word(16'h10F0, 1'b1);
        chk("R6 pause at level", ddmardy_n, 1);
        chk("R7 dmarq kept in pause", dmarq, 1);
        // R8 words in the pause window are kept
        send_word(16'h2001, 1'b1);
        send_word(16'h2002, 1'b1);
        step(60);
        chk("R7 dmarq dropped", dmarq, 0);
        chk("R7 tRP spacing", t_fall - t_rise, T_RP);
        send_word(16'hDEAD, 1'b0);
        chk("R8 overflow flag", rx_overflow, 1);
        release_burst();
        chk("R10 idle dmarq", dmarq, 0);
        chk("R10 idle ready", ddmardy_n, 1);

        // R5 start with a full buffer: no pause before first word
        start_burst();
        step(10);
        chk("R5 ready asserted", ddmardy_n, 0);
        step(30);
        chk("R5 ready still asserted", ddmardy_n, 0);
        chk("R5 dmarq still asserted", dmarq, 1);
        send_word(16'hBEEF, 1'b0);
        chk("R5 pause after first word", ddmardy_n, 1);
        release_burst();
        chk("R8 overflow sticky", rx_overflow, 1);
        rx_ready = 1'b1;
        step(30);
        chk("R8 words after drain", rx_cnt, 14);

        // R6 resume, then R9 host stop
        rx_ready = 1'b0;
        start_burst();
        step(10);
        for (int i = 0; i < AF_LVL; i++) send_word(16'h3000 + 16'(i), 1'b1);
        chk("R6 paused again", ddmardy_n, 1);
        rx_ready = 1'b1;
        step(10);
        chk("R6 resumed", ddmardy_n, 0);
        chk("R6 dmarq kept", dmarq, 1);
        send_word(16'h4001, 1'b1);
        send_word(16'h4002, 1'b1);
        stop = 1'b1;
        step(5);
        chk("R9 dmarq negated", dmarq, 0);
        chk("R9 ready negated", ddmardy_n, 1);
        release_burst();
        chk("R10 idle after stop", dmarq, 0);
        step(10);

        chk("R4 total words", rx_cnt, exp_cnt);
        for (int i = 6; i < exp_cnt; i++) chk("R8 stored word", rx_mem[i], exp_mem[i]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule